// File: doc/BRIEF.md
# Reorder Buffer with Flush Recovery

This block keeps program order for an out-of-order core. Each instruction receives an entry at the tail of a circular buffer when it is dispatched. The entry holds the instruction address, the destination register, a speculative flag, and a result slot that serves as its physical register. Execution units report results out of order through a completion port that names the entry index. Entries leave from the head strictly in allocation order. A retiring entry drives a commit port that writes the architectural register file, so that file only ever holds in-order state.

Recovery happens at the head. An entry that completed with a non-zero exception code is not committed. Allocation stops for that cycle, the whole buffer is discarded, and the faulting address goes out on the redirect port so the core can restart or abort. A branch that completed as mispredicted retires normally and discards every younger entry. For such a branch, the completion data carries the correct-path address, for example the fall-through address of a branch that was wrongly predicted taken. That address is placed on the redirect port.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: alloc_ready is 1, alloc_idx is 0, and commit_valid and flush_valid are 0.
- R2: An accepted allocation (alloc_valid and alloc_ready both high at a clock edge) takes the entry named by alloc_idx. alloc_idx then advances by one, modulo DEPTH.
- R3: The buffer holds at most DEPTH entries. While it is full, alloc_ready is 0 and an alloc_valid request changes nothing.
- R4: When the oldest entry is complete with exception code 0, commit_valid is 1 in that cycle. commit_pc, commit_dst, commit_data and commit_spec then show that entry's allocated PC, destination, completed data and speculative flag, and the entry is released at the clock edge.
- R5: At most one entry commits per cycle, in allocation order. A completed entry never commits while an older entry is still incomplete.
- R6: A completion aimed at an entry that is not allocated, or that a flush has discarded, has no effect. A later allocation of that index starts out incomplete.
- R7: When the oldest entry is complete with a non-zero exception code, flush_valid and flush_exc are 1, flush_code carries that code and flush_pc that entry's PC. commit_valid and alloc_ready are 0 in that cycle. In the next cycle the buffer is empty and alloc_idx equals the faulting entry's index.
- R8: When the oldest entry is complete with mispredict set and code 0, it commits and flush_valid is 1 with flush_exc 0 and flush_pc equal to its completion data. All younger entries are discarded, and alloc_idx next names the entry just after the branch.
- R9: Completion and allocation are refused in any cycle in which flush_valid is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Dispatch requests an entry |
| alloc_pc | input | PC_W | Instruction address |
| alloc_dst | input | REG_W | Destination architectural register |
| alloc_spec | input | 1 | Instruction issued under an unresolved branch |
| alloc_ready | output | 1 | Entry available and no flush in progress |
| alloc_idx | output | IDX_W | Index given to the allocated entry |
| cmpl_valid | input | 1 | Writeback reports a result |
| cmpl_idx | input | IDX_W | Entry the result belongs to |
| cmpl_data | input | DATA_W | Result value, or correct-path PC for a branch |
| cmpl_exc | input | EXC_W | Exception code, 0 for none |
| cmpl_mispred | input | 1 | Branch was mispredicted |
| commit_valid | output | 1 | Register file write this cycle |
| commit_dst | output | REG_W | Register written |
| commit_data | output | DATA_W | Value written |
| commit_pc | output | PC_W | Address of the retiring instruction |
| commit_spec | output | 1 | Speculative flag of the retiring instruction |
| flush_valid | output | 1 | Redirect and discard this cycle |
| flush_exc | output | 1 | Redirect caused by an exception |
| flush_code | output | EXC_W | Exception code of the faulting entry |
| flush_pc | output | PC_W | Address to restart fetch from |

## Verification
The bound checker tests several rules on every cycle. The allocate handshake stays low while the buffer is full or a flush is under way. The entry index advances by exactly one per accepted allocation. An exception flush never coincides with a commit and always leaves the buffer empty. A mispredict flush always retires the branch, and nothing commits from an empty buffer. Other properties depend on data and history: that commits leave in allocation order with the right payload, that stray completions leave no trace, and that squashed entries never reach the commit port. Only the bench's scenarios show these, through out-of-order completion, a full wrap of the buffer, an exception behind completed younger work, and a mispredicted branch.

// File: rtl/reorder_buffer.sv
module reorder_buffer #(
  parameter int DEPTH  = 8,
  parameter int PC_W   = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 5,
  parameter int EXC_W  = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [PC_W-1:0]   alloc_pc,
  input  logic [REG_W-1:0]  alloc_dst,
  input  logic              alloc_spec,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              cmpl_valid,
  input  logic [IDX_W-1:0]  cmpl_idx,
  input  logic [DATA_W-1:0] cmpl_data,
  input  logic [EXC_W-1:0]  cmpl_exc,
  input  logic              cmpl_mispred,
  output logic              commit_valid,
  output logic [REG_W-1:0]  commit_dst,
  output logic [DATA_W-1:0] commit_data,
  output logic [PC_W-1:0]   commit_pc,
  output logic              commit_spec,
  output logic              flush_valid,
  output logic              flush_exc,
  output logic [EXC_W-1:0]  flush_code,
  output logic [PC_W-1:0]   flush_pc
);
  localparam int PTR_W = IDX_W + 1;

  logic [DEPTH-1:0]  ent_valid, ent_done, ent_spec, ent_mis;
  logic [PC_W-1:0]   ent_pc   [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];
  logic [REG_W-1:0]  ent_dst  [DEPTH];
  logic [EXC_W-1:0]  ent_exc  [DEPTH];

  logic [PTR_W-1:0] head_ptr, tail_ptr, occ;
  logic [IDX_W-1:0] head_idx;
  logic             full, head_ready, head_faults, exc_flush, mis_flush;
  logic             alloc_fire, cmpl_hit;

  assign head_idx    = head_ptr[IDX_W-1:0];
  assign alloc_idx   = tail_ptr[IDX_W-1:0];
  assign occ         = tail_ptr - head_ptr;
  assign full        = (occ == PTR_W'(DEPTH));

  assign head_ready  = ent_valid[head_idx] && ent_done[head_idx];
  assign head_faults = (ent_exc[head_idx] != '0);
  assign exc_flush   = head_ready && head_faults;
  assign mis_flush   = head_ready && !head_faults && ent_mis[head_idx];

  assign commit_valid = head_ready && !head_faults;
  assign commit_dst   = ent_dst[head_idx];
  assign commit_data  = ent_data[head_idx];
  assign commit_pc    = ent_pc[head_idx];
  assign commit_spec  = ent_spec[head_idx];

  assign flush_valid = exc_flush || mis_flush;
  assign flush_exc   = exc_flush;
  assign flush_code  = ent_exc[head_idx];
  assign flush_pc    = exc_flush ? ent_pc[head_idx] : PC_W'(ent_data[head_idx]);

  assign alloc_ready = !full && !flush_valid;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign cmpl_hit    = cmpl_valid && ent_valid[cmpl_idx] && !flush_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_ptr <= '0;
      tail_ptr <= '0;
    end else if (exc_flush) begin
      tail_ptr <= head_ptr;
    end else if (mis_flush) begin
      head_ptr <= head_ptr + 1'b1;
      tail_ptr <= head_ptr + 1'b1;
    end else begin
      if (commit_valid) head_ptr <= head_ptr + 1'b1;
      if (alloc_fire)   tail_ptr <= tail_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_done  <= '0;
    end else if (flush_valid) begin
      ent_valid <= '0;
      ent_done  <= '0;
    end else begin
      if (commit_valid) begin
        ent_valid[head_idx] <= 1'b0;
        ent_done[head_idx]  <= 1'b0;
      end
      if (cmpl_hit) ent_done[cmpl_idx] <= 1'b1;
      if (alloc_fire) begin
        ent_valid[alloc_idx] <= 1'b1;
        ent_done[alloc_idx]  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) begin
      ent_pc[alloc_idx]   <= alloc_pc;
      ent_dst[alloc_idx]  <= alloc_dst;
      ent_spec[alloc_idx] <= alloc_spec;
      ent_exc[alloc_idx]  <= '0;
      ent_mis[alloc_idx]  <= 1'b0;
    end
    if (cmpl_hit) begin
      ent_data[cmpl_idx] <= cmpl_data;
      ent_exc[cmpl_idx]  <= cmpl_exc;
      ent_mis[cmpl_idx]  <= cmpl_mispred;
    end
  end
endmodule

// File: rtl/reorder_buffer_chk.sv
module reorder_buffer_chk #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W:0]   occ,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             commit_valid,
  input logic             flush_valid,
  input logic             flush_exc
);
  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (IDX_W+1)'(DEPTH)) |-> !alloc_ready);

  // R2
  idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)));

  // R7
  exc_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_exc) |-> !commit_valid);

  // R7
  exc_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && flush_exc) |=> (occ == '0));

  // R8
  mis_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !flush_exc) |-> commit_valid);

  // R9
  flush_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !alloc_ready);

  // R5
  empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> !commit_valid);
endmodule

bind reorder_buffer reorder_buffer_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .occ(occ), .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .commit_valid(commit_valid),
  .flush_valid(flush_valid), .flush_exc(flush_exc)
);

// File: tb/reorder_buffer_bench.sv
module reorder_buffer_bench;
  localparam int DEPTH = 8, PC_W = 32, DATA_W = 32, REG_W = 5, EXC_W = 4, IDX_W = 3;

  localparam logic [31:0] T_PC   [4] = '{32'h100, 32'h104, 32'h108, 32'h10C};
  localparam logic [4:0]  T_DST  [4] = '{5'd3, 5'd5, 5'd7, 5'd9};
  localparam logic [31:0] T_DATA [4] = '{32'h11, 32'h22, 32'h33, 32'h44};
  localparam logic        T_SPEC [4] = '{1'b0, 1'b1, 1'b0, 1'b1};

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_spec = 0, alloc_ready;
  logic [PC_W-1:0] alloc_pc = '0;
  logic [REG_W-1:0] alloc_dst = '0;
  logic [IDX_W-1:0] alloc_idx, cmpl_idx = '0;
  logic cmpl_valid = 0, cmpl_mispred = 0;
  logic [DATA_W-1:0] cmpl_data = '0;
  logic [EXC_W-1:0] cmpl_exc = '0;
  logic commit_valid, commit_spec, flush_valid, flush_exc;
  logic [REG_W-1:0] commit_dst;
  logic [DATA_W-1:0] commit_data;
  logic [PC_W-1:0] commit_pc, flush_pc;
  logic [EXC_W-1:0] flush_code;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  reorder_buffer u_reorder_buffer (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_dst(alloc_dst),
    .alloc_spec(alloc_spec), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .cmpl_data(cmpl_data),
    .cmpl_exc(cmpl_exc), .cmpl_mispred(cmpl_mispred),
    .commit_valid(commit_valid), .commit_dst(commit_dst), .commit_data(commit_data),
    .commit_pc(commit_pc), .commit_spec(commit_spec),
    .flush_valid(flush_valid), .flush_exc(flush_exc), .flush_code(flush_code),
    .flush_pc(flush_pc)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic alloc_one(input logic [31:0] pc, input logic [4:0] dst, input logic spec);
    alloc_valid = 1; alloc_pc = pc; alloc_dst = dst; alloc_spec = spec;
    step();
    alloc_valid = 0;
  endtask

  task automatic complete(input int idx, input logic [31:0] data, input logic [3:0] exc,
                          input logic mis);
    cmpl_valid = 1; cmpl_idx = IDX_W'(idx); cmpl_data = data; cmpl_exc = exc;
    cmpl_mispred = mis;
    step();
    cmpl_valid = 0; cmpl_exc = '0; cmpl_mispred = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 alloc_idx", alloc_idx, 0);
    chk("R1 commit_valid", commit_valid, 0);
    chk("R1 flush_valid", flush_valid, 0);

    // R2 table walk: allocate, then complete out of order
    for (int i = 0; i < 4; i++) begin
      chk("R2 alloc_idx", alloc_idx, i);
      alloc_one(T_PC[i], T_DST[i], T_SPEC[i]);
    end
    for (int i = 3; i >= 1; i--) begin
      complete(i, T_DATA[i], 0, 0);
      chk("R5 blocked by older", commit_valid, 0);
    end
    complete(0, T_DATA[0], 0, 0);
    for (int i = 0; i < 4; i++) begin
      chk("R4 commit_valid", commit_valid, 1);
      chk("R4 commit_pc", commit_pc, T_PC[i]);
      chk("R4 commit_dst", commit_dst, T_DST[i]);
      chk("R4 commit_data", commit_data, T_DATA[i]);
      chk("R4 commit_spec", commit_spec, T_SPEC[i]);
      step();
    end
    chk("R5 drained", commit_valid, 0);

    // R3 fill, refuse, drain
    for (int k = 0; k < DEPTH; k++) begin
      chk("R3 fill idx", alloc_idx, (4 + k) % DEPTH);
      alloc_one(32'h200 + 32'(4 * k), 5'd1, 1'b0);
    end
    chk("R3 full ready", alloc_ready, 0);
    alloc_one(32'hDEAD, 5'd2, 1'b0);
    for (int k = DEPTH - 1; k >= 0; k--) complete((4 + k) % DEPTH, 32'(k), 0, 0);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R3 drain pc", commit_pc, 32'h200 + 32'(4 * k));
      chk("R3 drain valid", commit_valid, 1);
      step();
    end
    chk("R3 no extra commit", commit_valid, 0);
    chk("R3 tail unchanged", alloc_idx, 4);

    // R6 stray completion ignored
    complete(4, 32'h99, 0, 0);
    alloc_one(32'h300, 5'd2, 1'b0);
    chk("R6 stray ignored", commit_valid, 0);
    complete(4, 32'h55, 0, 0);
    chk("R6 commit after real", commit_valid, 1);
    chk("R6 data", commit_data, 32'h55);
    step();

    // R7 exception at head
    alloc_one(32'h400, 5'd3, 1'b0);
    alloc_one(32'h404, 5'd4, 1'b1);
    alloc_one(32'h408, 5'd6, 1'b1);
    complete(6, 32'h66, 0, 0);
    complete(7, 32'h77, 0, 0);
    complete(5, 32'h0, 4'd3, 0);
    chk("R7 flush_valid", flush_valid, 1);
    chk("R7 flush_exc", flush_exc, 1);
    chk("R7 flush_code", flush_code, 3);
    chk("R7 flush_pc", flush_pc, 32'h400);
    chk("R7 no commit", commit_valid, 0);
    chk("R7 alloc halted", alloc_ready, 0);
    alloc_valid = 1; alloc_pc = 32'hBAD;
    step();
    alloc_valid = 0;
    chk("R7 after flush", flush_valid, 0);
    chk("R7 younger gone", commit_valid, 0);
    chk("R9 refused alloc", alloc_idx, 5);

    // R8 mispredicted branch
    alloc_one(32'h500, 5'd0, 1'b0);
    alloc_one(32'h504, 5'd4, 1'b1);
    alloc_one(32'h508, 5'd6, 1'b1);
    complete(6, 32'h1, 0, 0);
    complete(7, 32'h2, 0, 0);
    complete(5, 32'h600, 0, 1);
    chk("R8 commit branch", commit_valid, 1);
    chk("R8 commit_pc", commit_pc, 32'h500);
    chk("R8 flush_valid", flush_valid, 1);
    chk("R8 flush_exc", flush_exc, 0);
    chk("R8 flush_pc", flush_pc, 32'h600);
    complete(6, 32'h3, 0, 0);
    chk("R8 younger gone", commit_valid, 0);
    chk("R8 tail after branch", alloc_idx, 6);
    alloc_one(32'h700, 5'd8, 1'b0);
    chk("R9 completion in flush ignored", commit_valid, 0);
    complete(6, 32'h88, 0, 0);
    chk("R8 resume commit", commit_data, 32'h88);
    chk("R8 resume pc", commit_pc, 32'h700);
    step();
    finish_run();
  end
endmodule